// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block sits on the host side of an SMBus segment and acts as a target. A byte-level bus front end, which handles the individual bits and clock stretching, hands it start and stop events and every received byte. The block answers each byte with an acknowledge decision. It picks out the Host Notify messages that a device, acting as bus master, writes to the host's own address. From each one it keeps the device address and the 16-bit status word.

A Host Notify frame looks like a write-word transfer. The byte that would normally select a register carries the address of the device that is reporting. The two data bytes follow, low byte first. The block queues each complete frame in a small FIFO and holds an interrupt line high while entries are waiting. Software reads the oldest entry from the head outputs and removes it with a pop strobe. When the queue is full, the block refuses the address so that the device retries later. Frames that are broken off early, or that carry too many bytes, are dropped and counted.

Top module: `smbus_hnotify_rx`

## Requirements
- R1: After reset, `irq` is low, `err_count` is zero and `ack_valid` is low.
- R2: Every received byte (`rx_valid` high) gets exactly one response on `ack_valid` in the next cycle, and no response appears otherwise. The first byte after a start is the address byte: bits 7:1 hold the address and bit 0 is the direction, with 0 meaning write. It is acknowledged (`ack_bit`=1) only when bits 7:1 equal the host address, bit 0 is 0 and the FIFO is not full. Any other address byte is refused, and the bytes up to the next start are refused and ignored without counting an error.
- R3: After an accepted address, the device address byte, the low data byte and the high data byte are each acknowledged.
- R4: A frame made of a start, an accepted address, three bytes and then a stop queues one entry. Its device address is bits 7:1 of the first byte after the address, and its word is {high byte, low byte}.
- R5: `note_dev`/`note_word` show the oldest queued entry, and entries leave in arrival order. `note_pop` removes the head entry, and a pop while the queue is empty has no effect.
- R6: `irq` is high exactly while at least one entry is queued. It rises in the cycle after the stop of a valid frame.
- R7: While `FIFO_DEPTH` entries (4 by default) are queued, a matching address byte is refused. That frame is not queued and does not count as an error.
- R8: A stop or a start that arrives after an accepted address but before all three payload bytes discards the frame and adds one to `err_count`. This includes a frame with no payload bytes at all.
- R9: After the high byte, a fifth byte is refused, the frame is discarded and `err_count` goes up by one. A start in place of the stop likewise discards the frame and counts one error.
- R10: `err_count` saturates at its largest value (255 by default) and does not wrap.
- R11: The host address is taken from `cfg_host_addr` when the address byte is received (0x08 by convention). Changing it moves the matching to the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_host_addr | input | 7 | Host target address |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| rx_valid | input | 1 | A byte written by the bus master is available |
| rx_byte | input | 8 | The received byte |
| ack_valid | output | 1 | Acknowledge decision valid for the last byte |
| ack_bit | output | 1 | 1 = acknowledge, 0 = refuse |
| note_pop | input | 1 | Remove the head notification |
| irq | output | 1 | Notifications waiting |
| note_dev | output | 7 | Device address of the head entry |
| note_word | output | 16 | Status word of the head entry |
| err_count | output | ERR_W | Saturating count of discarded malformed frames |

## Verification
The bench sends clean notify frames with distinct device addresses and words. These show whether the low and high bytes are swapped and whether the device address is taken from the right bits. Frames to a foreign address and read-direction frames to the host address separate address matching from plain byte counting. Frames broken off at every position, from no payload up to an extra fifth byte, separate silent drops from counted errors. Filling the queue and then sending one more frame shows that the address is refused at full. A changed configured address and a long run of aborted frames exercise the address input and counter saturation.

// File: rtl/hn_pkg.sv
package hn_pkg;
   typedef enum logic [2:0] {
      FS_IDLE = 3'd0,
      FS_ADDR = 3'd1,
      FS_DEV  = 3'd2,
      FS_LO   = 3'd3,
      FS_HI   = 3'd4,
      FS_DONE = 3'd5,
      FS_SKIP = 3'd6
   } frm_state_t;

   localparam int DEV_W  = 7;
   localparam int WORD_W = 16;

   typedef struct packed {
      logic [DEV_W-1:0]  dev;
      logic [WORD_W-1:0] word;
   } note_t;

   localparam int NOTE_W = DEV_W + WORD_W;
endpackage

// File: rtl/hn_fifo.sv
module hn_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 23
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hn_fifo: DEPTH must be a power of two, at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hn_fifo: W must be positive");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_wr, do_rd;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_rd   = rd_en && !empty;
   assign do_wr   = wr_en && !full;
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_rd) rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
      end
   end
endmodule

// File: rtl/hn_err_cnt.sv
module hn_err_cnt #(
   parameter int ERR_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [ERR_W-1:0] count
);
   if (ERR_W < 1) begin : g_bad_w
      $error("hn_err_cnt: ERR_W must be positive");
   end

   logic [ERR_W-1:0] nxt;

   if (SATURATE) begin : g_sat
      always_comb nxt = (&count) ? count : count + ERR_W'(1);
   end else begin : g_wrap
      always_comb nxt = count + ERR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= nxt;
   end
endmodule

// File: rtl/hn_frame.sv
module hn_frame
   import hn_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [6:0]   host_addr,
   input  logic         ev_start,
   input  logic         ev_stop,
   input  logic         byte_vld,
   input  logic [7:0]   byte_data,
   input  logic         q_full,
   output logic         rsp_vld,
   output logic         rsp_ack,
   output logic         push,
   output note_t        push_note,
   output logic         err_pulse,
   output frm_state_t   state
);
   frm_state_t   nxt;
   logic         ack_nxt;
   logic [6:0]   dev_q;
   logic [7:0]   lo_q, hi_q;
   logic         in_payload;
   logic         addr_hit;

   assign in_payload = (state == FS_DEV) || (state == FS_LO) || (state == FS_HI);
   assign addr_hit   = (byte_data[7:1] == host_addr) && !byte_data[0] && !q_full;

   always_comb begin
      nxt       = state;
      ack_nxt   = 1'b0;
      push      = 1'b0;
      err_pulse = 1'b0;
      if (ev_stop) begin
         err_pulse = in_payload;
         push      = (state == FS_DONE);
         nxt       = FS_IDLE;
      end else if (ev_start) begin
         err_pulse = in_payload || (state == FS_DONE);
         nxt       = FS_ADDR;
      end else if (byte_vld) begin
         unique case (state)
            FS_ADDR: begin
               ack_nxt = addr_hit;
               nxt     = addr_hit ? FS_DEV : FS_SKIP;
            end
            FS_DEV: begin
               ack_nxt = 1'b1;
               nxt     = FS_LO;
            end
            FS_LO: begin
               ack_nxt = 1'b1;
               nxt     = FS_HI;
            end
            FS_HI: begin
               ack_nxt = 1'b1;
               nxt     = FS_DONE;
            end
            FS_DONE: begin
               err_pulse = 1'b1;
               nxt       = FS_SKIP;
            end
            default: nxt = state;
         endcase
      end
   end

   assign push_note.dev  = dev_q;
   assign push_note.word = {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= FS_IDLE;
         rsp_vld <= 1'b0;
         rsp_ack <= 1'b0;
         dev_q   <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         state   <= nxt;
         rsp_vld <= byte_vld;
         rsp_ack <= ack_nxt;
         if (byte_vld && !ev_start && !ev_stop) begin
            if (state == FS_DEV) dev_q <= byte_data[7:1];
            if (state == FS_LO)  lo_q  <= byte_data;
            if (state == FS_HI)  hi_q  <= byte_data;
         end
      end
   end
endmodule

// File: rtl/smbus_hnotify_rx.sv
module smbus_hnotify_rx
   import hn_pkg::*;
#(
   parameter int         FIFO_DEPTH     = 4,
   parameter int         ERR_W          = 8,
   parameter bit         ERR_SATURATE   = 1'b1,
   parameter bit         ADDR_FROM_PORT = 1'b1,
   parameter logic [6:0] HOST_ADDR      = 7'h08
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [6:0]       cfg_host_addr,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   output logic             ack_valid,
   output logic             ack_bit,
   input  logic             note_pop,
   output logic             irq,
   output logic [6:0]       note_dev,
   output logic [15:0]      note_word,
   output logic [ERR_W-1:0] err_count
);
   if (ERR_W < 1 || ERR_W > 32) begin : g_bad_err_w
      $error("smbus_hnotify_rx: ERR_W out of range");
   end

   logic [6:0]  host_addr;
   logic        frm_push, frm_err, fifo_full, fifo_empty;
   note_t       push_note, head_note;
   frm_state_t  frm_state;

   if (ADDR_FROM_PORT) begin : g_addr_port
      assign host_addr = cfg_host_addr;
   end else begin : g_addr_fixed
      assign host_addr = HOST_ADDR;
   end

   hn_frame u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_addr (host_addr),
      .ev_start  (bus_start),
      .ev_stop   (bus_stop),
      .byte_vld  (rx_valid),
      .byte_data (rx_byte),
      .q_full    (fifo_full),
      .rsp_vld   (ack_valid),
      .rsp_ack   (ack_bit),
      .push      (frm_push),
      .push_note (push_note),
      .err_pulse (frm_err),
      .state     (frm_state)
   );

   hn_fifo #(.DEPTH(FIFO_DEPTH), .W(NOTE_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (frm_push),
      .wr_data (push_note),
      .rd_en   (note_pop),
      .rd_data (head_note),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   hn_err_cnt #(.ERR_W(ERR_W), .SATURATE(ERR_SATURATE)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (frm_err),
      .count (err_count)
   );

   assign irq       = !fifo_empty;
   assign note_dev  = head_note.dev;
   assign note_word = head_note.word;
endmodule

// File: rtl/hn_checker.sv
module hn_checker
   import hn_pkg::*;
#(
   parameter int ERR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             bus_start,
   input logic             bus_stop,
   input logic             ack_valid,
   input logic             ack_bit,
   input logic             push,
   input logic             fifo_full,
   input logic             irq,
   input logic             note_pop,
   input frm_state_t       state,
   input logic [ERR_W-1:0] err_count
);
   p_ack_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> ack_valid);

   p_no_stray_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !ack_valid);

   p_full_addr_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !bus_start && !bus_stop && state == FS_ADDR && fifo_full) |=> !ack_bit);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !fifo_full);

   p_push_raises_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> irq);

   p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (note_pop && !irq && !push) |=> !irq);

   p_err_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_count) |-> (err_count - $past(err_count)) == ERR_W'(1));
endmodule

bind smbus_hnotify_rx hn_checker #(.ERR_W(ERR_W)) u_hn_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .bus_start (bus_start),
   .bus_stop  (bus_stop),
   .ack_valid (ack_valid),
   .ack_bit   (ack_bit),
   .push      (frm_push),
   .fifo_full (fifo_full),
   .irq       (irq),
   .note_pop  (note_pop),
   .state     (frm_state),
   .err_count (err_count)
);

// File: tb/tb_smbus_hnotify_rx.sv
module tb_smbus_hnotify_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  cfg_host_addr = 7'h08;
   logic        bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, note_pop = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        ack_valid, ack_bit, irq;
   logic [6:0]  note_dev;
   logic [15:0] note_word;
   logic [7:0]  err_count;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   smbus_hnotify_rx dut (
      .clk(clk), .rst_n(rst_n), .cfg_host_addr(cfg_host_addr),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .ack_valid(ack_valid), .ack_bit(ack_bit),
      .note_pop(note_pop), .irq(irq),
      .note_dev(note_dev), .note_word(note_word), .err_count(err_count)
   );

   // behavioural reference model
   int          m_st;
   logic [22:0] m_q[$];
   logic [6:0]  m_dev;
   logic [7:0]  m_lo, m_hi;
   int          m_err;
   bit          m_rv, m_ack;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_q.delete(); m_err = 0; m_rv = 0; m_ack = 0;
      end else begin
         bit pushit, errit;
         int sz;
         pushit = 0; errit = 0; sz = m_q.size();
         m_rv = rx_valid; m_ack = 0;
         if (bus_stop) begin
            if (m_st >= 2 && m_st <= 4) errit = 1;
            if (m_st == 5) pushit = 1;
            m_st = 0;
         end else if (bus_start) begin
            if (m_st >= 2 && m_st <= 5) errit = 1;
            m_st = 1;
         end else if (rx_valid) begin
            case (m_st)
               1: if (rx_byte[7:1] == cfg_host_addr && rx_byte[0] == 1'b0 && sz < 4) begin
                     m_ack = 1; m_st = 2;
                  end else m_st = 6;
               2: begin m_dev = rx_byte[7:1]; m_ack = 1; m_st = 3; end
               3: begin m_lo = rx_byte; m_ack = 1; m_st = 4; end
               4: begin m_hi = rx_byte; m_ack = 1; m_st = 5; end
               5: begin errit = 1; m_st = 6; end
               default: ;
            endcase
         end
         if (note_pop && sz > 0) void'(m_q.pop_front());
         if (pushit) m_q.push_back({m_dev, m_hi, m_lo});
         if (errit && m_err < 255) m_err++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(ack_valid == m_rv, "R2", "ack_valid", ack_valid, m_rv);
         if (m_rv) check(ack_bit == m_ack, "R3", "ack_bit", ack_bit, m_ack);
         check(irq == (m_q.size() > 0), "R6", "irq", irq, m_q.size() > 0);
         if (m_q.size() > 0) begin
            check(note_dev == m_q[0][22:16], "R5", "note_dev", note_dev, m_q[0][22:16]);
            check(note_word == m_q[0][15:0], "R4", "note_word", note_word, m_q[0][15:0]);
         end
         check(err_count == m_err[7:0], "R8", "err_count", err_count, m_err);
      end
   end

   task automatic tick(); @(negedge clk); endtask
   task automatic ev_start(); @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0; endtask
   task automatic ev_stop();  @(negedge clk); bus_stop  = 1; @(negedge clk); bus_stop  = 0; endtask
   task automatic ev_byte(input logic [7:0] b);
      @(negedge clk); rx_valid = 1; rx_byte = b; @(negedge clk); rx_valid = 0;
   endtask
   task automatic do_pop(); @(negedge clk); note_pop = 1; @(negedge clk); note_pop = 0; endtask
   task automatic frame(input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] lo, input logic [7:0] hi);
      ev_start(); ev_byte(a); ev_byte(d); ev_byte(lo); ev_byte(hi); ev_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) tick();
      check(irq == 0 && err_count == 0 && ack_valid == 0, "R1", "reset state",
            {irq, ack_valid, err_count}, 0);
      rst_n = 1;
      tick();

      // R4 R6 clean frame, device 0x2D, word 0x1234
      frame(8'h10, 8'h5A, 8'h34, 8'h12);
      tick();
      check(irq == 1, "R6", "irq after frame", irq, 1);
      check(note_dev == 7'h2D, "R4", "device address", note_dev, 7'h2D);
      check(note_word == 16'h1234, "R4", "word order", note_word, 16'h1234);

      // R2 foreign address and read direction ignored
      frame(8'h22, 8'h01, 8'h02, 8'h03);
      frame(8'h11, 8'h01, 8'h02, 8'h03);
      tick();
      check(err_count == 0, "R2", "ignored frames no error", err_count, 0);

      // R5 pop, then pop on empty
      do_pop(); tick();
      check(irq == 0, "R5", "pop empties queue", irq, 0);
      do_pop(); tick();
      check(irq == 0, "R5", "pop on empty", irq, 0);

      // R7 fill the queue then one more frame
      for (int i = 0; i < 4; i++) frame(8'h10, 8'(8'h20 + 2 * i), 8'(i), 8'(8'hA0 + i));
      frame(8'h10, 8'h7E, 8'hEE, 8'hFF);
      tick();
      check(err_count == 0, "R7", "full refusal no error", err_count, 0);
      for (int i = 0; i < 4; i++) begin
         check(note_word == {8'(8'hA0 + i), 8'(i)}, "R5", "fifo order", note_word,
               {8'(8'hA0 + i), 8'(i)});
         do_pop();
      end
      tick();
      check(irq == 0, "R7", "fifth frame not queued", irq, 0);

      // R8 cut short
      ev_start(); ev_byte(8'h10); ev_stop();                      // no payload
      ev_start(); ev_byte(8'h10); ev_byte(8'h44); ev_stop();      // stop after device
      ev_start(); ev_byte(8'h10); ev_byte(8'h44); ev_byte(8'h01); ev_start(); ev_stop();
      tick();
      check(err_count == 3, "R8", "aborted frames counted", err_count, 3);
      check(irq == 0, "R8", "aborted frames not queued", irq, 0);

      // R9 extra byte, start in place of stop
      ev_start(); ev_byte(8'h10); ev_byte(8'h44); ev_byte(8'h01); ev_byte(8'h02); ev_byte(8'h03); ev_stop();
      ev_start(); ev_byte(8'h10); ev_byte(8'h44); ev_byte(8'h01); ev_byte(8'h02); ev_start(); ev_stop();
      tick();
      check(err_count == 5, "R9", "overlong and restarted counted", err_count, 5);
      check(irq == 0, "R9", "overlong not queued", irq, 0);

      // R11 configured address
      cfg_host_addr = 7'h33;
      frame(8'h10, 8'h12, 8'h55, 8'h66);
      frame(8'h66, 8'h14, 8'h77, 8'h88);
      tick();
      check(note_dev == 7'h0A && note_word == 16'h8877, "R11", "new address match",
            {note_dev, note_word}, {7'h0A, 16'h8877});
      do_pop();
      cfg_host_addr = 7'h08;

      // R10 saturation
      for (int i = 0; i < 260; i++) begin
         ev_start(); ev_byte(8'h10); ev_stop();
      end
      tick();
      check(err_count == 8'hFF, "R10", "counter saturates", err_count, 8'hFF);

      tick();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule